// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is the initiator side of a synchronous shared bus on which one set of lines carries the address and then the data words of a transaction. A local client starts a transfer by giving a start address, a direction, a byte-enable mask and a word count. The controller then asks a central arbiter for ownership. Once ownership is granted it drives a single address cycle and moves the data words as one burst. Reads get one quiet turnaround cycle after the address cycle. Either side can stretch any data word with its wait line. The target can cut the burst short with its stop line. The controller uses its own stop line to mark the final word.

The bus lines are brought out as separate output, output-enable and input vectors, and the pad ring builds the tri-state buffers from them. When the arbiter takes the grant away during a burst, the current word still completes. The controller then drops the bus for one cycle, asks again and resumes with a fresh address cycle at the next word's address. When a transaction ends, the client receives a one-cycle completion pulse with the number of words moved and a flag telling whether the target stopped the transfer.

Top module: `mad_bus_master`

## Requirements
- R1: While reset is held and right after it, bus_req, ad_oe, cbe_oe, bus_frame, rd_valid and done are low, and req_ready is high.
- R2: A start accepted while req_ready is high raises bus_req in the next cycle. bus_frame and ad_oe stay low until bus_gnt has been sampled high at a clock edge while bus_req is high. The address cycle is the cycle after that edge.
- R3: The address cycle lasts exactly one cycle, with ad_oe, cbe_oe and bus_frame high and ad_o equal to the transfer address. cbe_n carries the command: 4'b0110 for a read, 4'b0111 for a write.
- R4: On a write, data cycles follow the address cycle at once. In each data cycle ad_o carries the write word whose number is on wr_idx (0 is the first word), and cbe_n carries the bitwise inverse of req_ben.
- R5: On a read, exactly one turnaround cycle follows the address cycle, with bus_frame high and ad_oe low. ad_oe stays low during the read data cycles. Each word taken from ad_i is presented on rd_data with rd_valid high one cycle after its transfer edge, and rd_idx gives its word number.
- R6: A data cycle in which loc_hold or t_wait is high moves no word. m_wait follows loc_hold during data cycles. wr_idx and the write word on ad_o hold their values until the word moves.
- R7: m_stop is high in exactly those data cycles in which the word still pending is the final word of the request.
- R8: If t_stop is high in a data cycle, the transaction ends at that edge. The current word counts only if neither wait line is high. done_stop reports the stop.
- R9: After the last word of a transaction, bus_req, bus_frame, ad_oe and cbe_oe are low in the next cycle, done pulses for one cycle, and done_count equals the number of words moved.
- R10: If bus_gnt is low at an edge where a word moves and the burst is not finished, the controller keeps bus_req low for one cycle and then requests again. After the new grant it issues a new address cycle at start address + 4 × words already moved.
- R11: ad_oe and cbe_oe are never high while bus_frame is low.
- R12: A request with a count of 0 ends right after the address cycle (write) or after the turnaround cycle (read), with no data cycle and done_count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start a transfer (taken when req_ready is high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Start byte address, word aligned |
| req_ben | input | 4 | Byte enables, active high |
| req_count | input | 8 | Number of words, 0 allowed |
| req_ready | output | 1 | Controller idle |
| wr_data | input | 32 | Write word for index wr_idx |
| wr_idx | output | 8 | Number of words already moved |
| loc_hold | input | 1 | Local side not ready, drives m_wait |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word |
| rd_idx | output | 8 | Word number of rd_data |
| done | output | 1 | Transaction finished (one cycle) |
| done_count | output | 8 | Words moved |
| done_stop | output | 1 | Ended by target stop |
| bus_req | output | 1 | Request to arbiter |
| bus_gnt | input | 1 | Grant from arbiter |
| ad_o | output | 32 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Drive enable for ad_o |
| ad_i | input | 32 | Shared address/data lines, received value |
| cbe_n | output | 4 | Command / active-low byte enables |
| cbe_oe | output | 1 | Drive enable for cbe_n |
| bus_frame | output | 1 | Transaction in progress on the bus |
| m_wait | output | 1 | Initiator wait |
| m_stop | output | 1 | Initiator marks final word |
| t_wait | input | 1 | Target wait |
| t_stop | input | 1 | Target stop |

## Verification
Bus-side responses (address cycle, turnaround, data words, m_stop, release) all follow from the state register. They are due in the cycle after the edge that caused them, and a start shows as bus_req one cycle later. Read words reach rd_data one cycle after their transfer edge. done and done_count arrive in the cycle after the final edge. The bench drives inputs and samples outputs on the falling edge. It models the target, arbiter and expected word counts as the cycles run, so each check compares the values that belong to the cycle just completed against that cycle's expectation.

// File: rtl/mad_pkg.sv
package mad_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_ADDR,
      ST_TURN,
      ST_DATA,
      ST_BACK
   } mad_state_e;
endpackage

// File: rtl/mad_xfer_cnt.sv
// Holds the request fields and tracks words moved and the running address.
module mad_xfer_cnt #(
   parameter int AD_W  = 32,
   parameter int CNT_W = 8,
   parameter int BE_W  = AD_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AD_W-1:0]  ld_addr,
   input  logic             ld_write,
   input  logic [BE_W-1:0]  ld_ben,
   input  logic [CNT_W-1:0] ld_count,
   input  logic             beat,
   output logic [CNT_W-1:0] cnt,
   output logic [AD_W-1:0]  cur_addr,
   output logic             is_write,
   output logic [BE_W-1:0]  ben,
   output logic             last_word,
   output logic             empty
);
   localparam logic [AD_W-1:0] STEP = AD_W'(BE_W);

   logic [CNT_W-1:0] total;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         cur_addr <= '0;
         total    <= '0;
         is_write <= 1'b0;
         ben      <= '0;
      end else if (load) begin
         cnt      <= '0;
         cur_addr <= ld_addr;
         total    <= ld_count;
         is_write <= ld_write;
         ben      <= ld_ben;
      end else if (beat) begin
         cnt      <= cnt + 1'b1;
         cur_addr <= cur_addr + STEP;
      end
   end

   assign last_word = ({1'b0, cnt} + 1'b1) == {1'b0, total};
   assign empty     = (total == '0);

   // count never passes the requested total
   assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !load) |-> (cnt != total));
endmodule

// File: rtl/mad_seq.sv
// Transaction sequencer: request, address, turnaround, data, back-off.
module mad_seq
   import mad_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       gnt,
   input  logic       is_write,
   input  logic       empty,
   input  logic       last_word,
   input  logic       loc_hold,
   input  logic       t_wait,
   input  logic       t_stop,
   output mad_state_e state,
   output logic       beat,
   output logic       done,
   output logic       done_stop,
   output logic       bus_req
);
   mad_state_e st_q, st_d;
   logic       fin;

   assign beat = (st_q == ST_DATA) && !loc_hold && !t_wait;

   always_comb begin
      st_d = st_q;
      fin  = 1'b0;
      unique case (st_q)
         ST_IDLE: if (start) st_d = ST_REQ;
         ST_REQ:  if (gnt) st_d = ST_ADDR;
         ST_ADDR: begin
            if (!is_write)  st_d = ST_TURN;
            else if (empty) begin st_d = ST_IDLE; fin = 1'b1; end
            else            st_d = ST_DATA;
         end
         ST_TURN: begin
            if (empty) begin st_d = ST_IDLE; fin = 1'b1; end
            else       st_d = ST_DATA;
         end
         ST_DATA: begin
            if (t_stop || (beat && last_word)) begin
               st_d = ST_IDLE;
               fin  = 1'b1;
            end else if (beat && !gnt) begin
               st_d = ST_BACK;
            end
         end
         ST_BACK: st_d = ST_REQ;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         done      <= 1'b0;
         done_stop <= 1'b0;
      end else begin
         st_q      <= st_d;
         done      <= fin;
         done_stop <= fin && t_stop && (st_q == ST_DATA);
      end
   end

   assign state   = st_q;
   assign bus_req = (st_q == ST_REQ) || (st_q == ST_ADDR) ||
                    (st_q == ST_TURN) || (st_q == ST_DATA);

   assert_req_waits_gnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_REQ && !gnt) |=> (st_q == ST_REQ));
   assert_addr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ADDR) |=> (st_q != ST_ADDR));
   assert_back_rerequest_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BACK) |=> (st_q == ST_REQ));
endmodule

// File: rtl/mad_rd_cap.sv
// Read word delivery: registered (default) or same-cycle pass-through.
module mad_rd_cap #(
   parameter int AD_W   = 32,
   parameter int CNT_W  = 8,
   parameter bit REG_RD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [AD_W-1:0]  ad_in,
   input  logic [CNT_W-1:0] idx,
   output logic             rd_valid,
   output logic [AD_W-1:0]  rd_data,
   output logic [CNT_W-1:0] rd_idx
);
   if (REG_RD) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_idx   <= '0;
         end else begin
            rd_valid <= cap;
            if (cap) begin
               rd_data <= ad_in;
               rd_idx  <= idx;
            end
         end
      end
      assert_rd_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
         cap |=> rd_valid);
   end else begin : g_pass
      assign rd_valid = cap;
      assign rd_data  = ad_in;
      assign rd_idx   = idx;
   end
endmodule

// File: rtl/mad_bus_master.sv
// Initiator for a shared multiplexed address/data bus.
module mad_bus_master
   import mad_pkg::*;
#(
   parameter int AD_W   = 32,
   parameter int CNT_W  = 8,
   parameter bit REG_RD = 1'b1,
   parameter int CMD_RD = 6,
   parameter int CMD_WR = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_start,
   input  logic             req_write,
   input  logic [31:0]      req_addr,
   input  logic [3:0]       req_ben,
   input  logic [CNT_W-1:0] req_count,
   output logic             req_ready,
   input  logic [31:0]      wr_data,
   output logic [CNT_W-1:0] wr_idx,
   input  logic             loc_hold,
   output logic             rd_valid,
   output logic [31:0]      rd_data,
   output logic [CNT_W-1:0] rd_idx,
   output logic             done,
   output logic [CNT_W-1:0] done_count,
   output logic             done_stop,
   output logic             bus_req,
   input  logic             bus_gnt,
   output logic [31:0]      ad_o,
   output logic             ad_oe,
   input  logic [31:0]      ad_i,
   output logic [3:0]       cbe_n,
   output logic             cbe_oe,
   output logic             bus_frame,
   output logic             m_wait,
   output logic             m_stop,
   input  logic             t_wait,
   input  logic             t_stop
);
   localparam int BE_W = AD_W / 8;
   localparam logic [BE_W-1:0] CMD_R = BE_W'(CMD_RD);
   localparam logic [BE_W-1:0] CMD_W = BE_W'(CMD_WR);

   if (AD_W != 32) begin : g_bad_w
      $error("mad_bus_master: AD_W must be 32 to match the port widths");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_c
      $error("mad_bus_master: CNT_W out of range");
   end
   if (CMD_RD >= (1 << BE_W) || CMD_WR >= (1 << BE_W) || CMD_RD == CMD_WR) begin : g_bad_cmd
      $error("mad_bus_master: command codes invalid");
   end

   mad_state_e       st;
   logic             beat, is_write, last_word, empty, load;
   logic [CNT_W-1:0] cnt;
   logic [AD_W-1:0]  cur_addr;
   logic [BE_W-1:0]  ben;
   logic             in_addr, in_turn, in_data;

   assign load = req_start && (st == ST_IDLE);

   mad_xfer_cnt #(.AD_W(AD_W), .CNT_W(CNT_W), .BE_W(BE_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .load(load),
      .ld_addr(req_addr), .ld_write(req_write), .ld_ben(req_ben),
      .ld_count(req_count), .beat(beat), .cnt(cnt), .cur_addr(cur_addr),
      .is_write(is_write), .ben(ben), .last_word(last_word), .empty(empty)
   );

   mad_seq i_seq (
      .clk(clk), .rst_n(rst_n), .start(load), .gnt(bus_gnt),
      .is_write(is_write), .empty(empty), .last_word(last_word),
      .loc_hold(loc_hold), .t_wait(t_wait), .t_stop(t_stop),
      .state(st), .beat(beat), .done(done), .done_stop(done_stop),
      .bus_req(bus_req)
   );

   mad_rd_cap #(.AD_W(AD_W), .CNT_W(CNT_W), .REG_RD(REG_RD)) i_rd (
      .clk(clk), .rst_n(rst_n), .cap(beat && !is_write), .ad_in(ad_i),
      .idx(cnt), .rd_valid(rd_valid), .rd_data(rd_data), .rd_idx(rd_idx)
   );

   assign in_addr = (st == ST_ADDR);
   assign in_turn = (st == ST_TURN);
   assign in_data = (st == ST_DATA);

   always_comb begin
      ad_o = '0;
      if (in_addr)                  ad_o = cur_addr;
      else if (in_data && is_write) ad_o = wr_data;
   end

   always_comb begin
      cbe_n = '1;
      if (in_addr)                 cbe_n = is_write ? CMD_W : CMD_R;
      else if (in_turn || in_data) cbe_n = ~ben;
   end

   assign ad_oe      = in_addr || (in_data && is_write);
   assign cbe_oe     = in_addr || in_turn || in_data;
   assign bus_frame  = cbe_oe;
   assign m_wait     = in_data && loc_hold;
   assign m_stop     = in_data && last_word;
   assign req_ready  = (st == ST_IDLE);
   assign wr_idx     = cnt;
   assign done_count = cnt;

   assert_grant_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_frame) |-> $past(bus_gnt));
   assert_turn_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_turn |-> (!ad_oe && bus_frame));
   assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && (loc_hold || t_wait) && !t_stop) |=> ($stable(wr_idx) && bus_frame));
   assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && t_stop) |=> (!bus_frame && done));
   assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!bus_req && !bus_frame && !ad_oe));
   assert_backoff_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_frame) && !done) |-> !bus_req);
   assert_oe_framed_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ad_oe || cbe_oe) |-> bus_frame);
endmodule

// File: tb/test_mad_bus_master.sv
module test_mad_bus_master;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic        req_start = 0, req_write = 0, loc_hold = 0;
   logic [31:0] req_addr = 0;
   logic [3:0]  req_ben = 0;
   logic [7:0]  req_count = 0;
   logic        req_ready, rd_valid, done, done_stop, bus_req;
   logic [31:0] wr_data, rd_data, ad_o;
   logic [7:0]  wr_idx, rd_idx, done_count;
   logic        bus_gnt = 0, ad_oe, cbe_oe, bus_frame, m_wait, m_stop;
   logic [31:0] ad_i = 0;
   logic [3:0]  cbe_n;
   logic        t_wait = 0, t_stop = 0;

   function automatic logic [31:0] wpat(input logic [7:0] i);
      return 32'hA5C30000 ^ ({24'd0, i} * 32'h01030507);
   endfunction
   function automatic logic [31:0] rfun(input logic [31:0] a);
      return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
   endfunction

   assign wr_data = wpat(wr_idx);

   mad_bus_master i_mad_bus_master (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
      .req_addr(req_addr), .req_ben(req_ben), .req_count(req_count),
      .req_ready(req_ready), .wr_data(wr_data), .wr_idx(wr_idx),
      .loc_hold(loc_hold), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_idx(rd_idx), .done(done), .done_count(done_count),
      .done_stop(done_stop), .bus_req(bus_req), .bus_gnt(bus_gnt),
      .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .cbe_n(cbe_n),
      .cbe_oe(cbe_oe), .bus_frame(bus_frame), .m_wait(m_wait),
      .m_stop(m_stop), .t_wait(t_wait), .t_stop(t_stop)
   );

   int n_chk = 0, n_bad = 0;
   // stimulus policy
   int p_twait = 0, p_hold = 0, p_stop = 0, p_drop = 0, gnt_delay = 0;
   // expected transaction
   bit          e_wr;
   logic [31:0] e_start;
   logic [3:0]  e_ben;
   int          e_n;
   // target / arbiter model state
   bit          frame_q = 0, tturn = 0, gnt_prev = 0, start_pend = 0, after_start = 0;
   bit          last_stop = 0, done_seen = 0;
   logic [31:0] taddr = 0;
   int          beats = 0, rd_seen = 0, req_age = 0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic step();
      bit in_data, bt;
      @(negedge clk);
      if (after_start) begin
         chk(bus_req && !bus_frame, "R2", {30'd0, bus_req, bus_frame}, 32'd2);
         after_start = 0;
      end
      in_data = bus_frame && frame_q && !tturn;
      req_start = start_pend;
      if (start_pend) after_start = 1;
      start_pend = 0;
      t_wait   = in_data && (($urandom % 100) < p_twait);
      loc_hold = (($urandom % 100) < p_hold);
      t_stop   = in_data && (($urandom % 100) < p_stop);
      if (bus_req) begin
         if (!bus_frame) req_age++;
         bus_gnt = (req_age > gnt_delay) && !(in_data && (($urandom % 100) < p_drop));
      end else begin
         req_age = 0;
         bus_gnt = 0;
      end
      ad_i = rfun(taddr);
      #1;
      if (!bus_frame) chk(!ad_oe && !cbe_oe, "R11", {30'd0, ad_oe, cbe_oe}, 32'd0);
      if (bus_frame && !frame_q) begin
         chk(gnt_prev, "R2", {31'd0, gnt_prev}, 32'd1);
         chk(ad_oe && cbe_oe, "R3", {30'd0, ad_oe, cbe_oe}, 32'd3);
         chk(cbe_n == (e_wr ? 4'b0111 : 4'b0110), "R3", {28'd0, cbe_n},
             e_wr ? 32'd7 : 32'd6);
         chk(ad_o == e_start + 32'(beats * 4), beats ? "R10" : "R3", ad_o,
             e_start + 32'(beats * 4));
         taddr = ad_o;
         tturn = !e_wr;
      end else if (bus_frame) begin
         if (tturn) begin
            chk(!ad_oe, "R5", {31'd0, ad_oe}, 32'd0);
            tturn = 0;
         end else begin
            bt = !loc_hold && !t_wait;
            chk(cbe_n == ~e_ben, "R4", {28'd0, cbe_n}, {28'd0, ~e_ben});
            chk(m_stop == (beats + 1 == e_n), "R7", {31'd0, m_stop},
                {31'd0, beats + 1 == e_n});
            chk(m_wait == loc_hold, "R6", {31'd0, m_wait}, {31'd0, loc_hold});
            if (e_wr) begin
               chk(ad_oe && ad_o == wpat(8'(beats)), bt ? "R4" : "R6", ad_o,
                   wpat(8'(beats)));
               chk(wr_idx == 8'(beats), "R6", {24'd0, wr_idx}, 32'(beats));
            end else begin
               chk(!ad_oe, "R5", {31'd0, ad_oe}, 32'd0);
            end
            last_stop = t_stop;
            if (bt) begin
               beats++;
               taddr = taddr + 32'd4;
            end
         end
      end else if (frame_q && !done) begin
         chk(!bus_req, "R10", {31'd0, bus_req}, 32'd0);
      end
      if (rd_valid) begin
         chk(!e_wr && rd_idx == 8'(rd_seen), "R5", {24'd0, rd_idx}, 32'(rd_seen));
         chk(rd_data == rfun(e_start + 32'(rd_seen * 4)), "R5", rd_data,
             rfun(e_start + 32'(rd_seen * 4)));
         rd_seen++;
      end
      if (done) begin
         done_seen = 1;
         chk(!bus_req && !ad_oe && !cbe_oe, "R9", {29'd0, bus_req, ad_oe, cbe_oe}, 32'd0);
         chk(done_count == 8'(beats), "R9", {24'd0, done_count}, 32'(beats));
         chk(done_stop == last_stop, "R8", {31'd0, done_stop}, {31'd0, last_stop});
         if (!last_stop) chk(beats == e_n, "R9", 32'(beats), 32'(e_n));
         if (!e_wr) chk(rd_seen == beats, "R5", 32'(rd_seen), 32'(beats));
         if (e_n == 0) chk(beats == 0 && done_count == 0, "R12", {24'd0, done_count}, 32'd0);
      end
      frame_q  = bus_frame;
      gnt_prev = bus_gnt;
   endtask

   task automatic run_txn(input bit wr, input logic [31:0] a, input logic [3:0] be,
                          input int n);
      int guard;
      while (!req_ready) step();
      e_wr = wr; e_start = a; e_ben = be; e_n = n;
      beats = 0; rd_seen = 0; last_stop = 0; done_seen = 0;
      req_write = wr; req_addr = a; req_ben = be; req_count = 8'(n);
      start_pend = 1;
      guard = 0;
      while (!done_seen && guard < 3000) begin
         step();
         guard++;
      end
      if (!done_seen) chk(0, "R9", 32'd0, 32'd1);
      step();
   endtask

   task automatic policy(input int tw, input int lh, input int ts, input int dr,
                         input int gd);
      p_twait = tw; p_hold = lh; p_stop = ts; p_drop = dr; gnt_delay = gd;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7741));
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(!bus_req && !ad_oe && !cbe_oe && !bus_frame && !rd_valid && !done && req_ready,
          "R1", {25'd0, bus_req, ad_oe, cbe_oe, bus_frame, rd_valid, done, req_ready},
          32'd1);
      rst_n = 1;
      step();
      chk(req_ready && !bus_req && !bus_frame, "R1",
          {29'd0, req_ready, bus_req, bus_frame}, 32'd4);
      // directed: plain write and read, late grant (R2, R3, R4, R5, R7)
      policy(0, 0, 0, 0, 3);
      run_txn(1, 32'h0000_1000, 4'b1111, 4);
      run_txn(0, 32'h0000_2000, 4'b0101, 4);
      // zero-length (R12)
      policy(0, 0, 0, 0, 0);
      run_txn(1, 32'h0000_3000, 4'b0011, 0);
      run_txn(0, 32'h0000_3100, 4'b1100, 0);
      // waits on both sides (R6)
      policy(40, 40, 0, 0, 1);
      run_txn(1, 32'h0000_4000, 4'b1010, 6);
      run_txn(0, 32'h0000_5000, 4'b1111, 6);
      // target stop (R8)
      policy(20, 0, 30, 0, 0);
      run_txn(1, 32'h0000_6000, 4'b1111, 12);
      run_txn(0, 32'h0000_7000, 4'b1111, 12);
      // preemption (R10)
      policy(10, 10, 0, 40, 2);
      run_txn(1, 32'h0000_8000, 4'b0110, 10);
      run_txn(0, 32'h0000_9000, 4'b1001, 10);
      // constrained random mix
      for (int k = 0; k < 60; k++) begin
         policy($urandom % 40, $urandom % 30, ($urandom % 4 == 0) ? 15 : 0,
                $urandom % 30, $urandom % 4);
         run_txn($urandom % 2, {$urandom % 32'h10000, 2'b00} & 32'h000F_FFFC,
                 4'($urandom), $urandom % 10);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule